// File: doc/BRIEF.md
# Control and Status Register File

This block holds the processor's control and status registers. The pipeline reaches them through a 5-bit index with two instructions: a read, which returns a register value, and a write, which updates one. The bank holds the following registers:

- interrupt enable, which holds a live enable bit and two saved copies;
- interrupt mask;
- interrupt pending, which hardware lines set and software clears;
- a free-running cycle counter;
- a fixed configuration word;
- the exception and debug-exception vector bases;
- a debug control word;
- up to four breakpoint and four watchpoint address registers.

The block also decodes two cache-control indexes into one-cycle flush pulses.

Not every register accepts both kinds of access. The counter and the configuration word can only be read. The cache controls and the breakpoint and watchpoint registers can only be written. An access in the wrong direction, or to an index with no register behind it, raises an access-error flag. Such an access changes no state, and a read of this kind returns zero. A write to a breakpoint or watchpoint slot at or above the configured count instead raises an illegal-instruction flag. A write to the enable, mask or pending register raises an update request, so the pipeline restarts at the next instruction under the new interrupt state.

Every result is registered. Read data and the three flags appear one clock after the access is presented. The interrupt comparators and the debug comparators sit outside this block.

Top module: `csr_bank`

## Requirements
- R1: While reset is held, every output is zero: read data, flags, flush pulses, enables, mask, pending, bases, debug control, and breakpoint and watchpoint values.
- R2: A write followed by a read returns the written value, one cycle after the read, for these indexes: enable (index 0, bits [2:0] kept, upper bits read 0), mask (index 1, low NUM_IRQ bits kept), exception base (7), debug control (8) and debug base (9).
- R3: A write to index 0, 1 or 2 sets upd_req in the next cycle. A write to any other index, and every read, leaves upd_req low.
- R4: Pending (index 2) ORs irq_lines into its bits on every clock. Each 1 in write data clears that bit. An irq line that is high in the same cycle as the clear wins. A read of index 2 returns the pending bits.
- R5: The cycle counter (index 5) advances by one every clock after reset. A read returns its value at the clock edge that samples the read.
- R6: Writes to the counter (5) or the configuration word (6) raise acc_err and change nothing. A read of index 6 always returns CFG_VALUE.
- R7: Reads of index 3, index 4, or indexes 16 to 23 raise acc_err and return zero.
- R8: A write to index 16+n stores breakpoint n, which appears on bp_addr[32n+31:32n], when n < NUM_BP. A write to index 20+n stores watchpoint n on wp_addr when n < NUM_WP. A write to a slot at or above the count raises ill_insn and leaves the value at zero.
- R9: Indexes 10 to 15 and 24 to 31 are unknown. Any access to one of them raises acc_err only, returns zero, and changes no register.
- R10: A write to index 3 pulses icache_flush high for one cycle. A write to index 4 pulses dcache_flush high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read access this cycle |
| wr_en | input | 1 | Write access this cycle |
| idx | input | 5 | Register index |
| wr_data | input | XLEN | Write value |
| irq_lines | input | NUM_IRQ | Interrupt request lines feeding pending |
| rd_data | output | XLEN | Registered read result |
| acc_err | output | 1 | Invalid-direction or unknown-index access |
| ill_insn | output | 1 | Write to an absent breakpoint or watchpoint slot |
| upd_req | output | 1 | Restart request after an interrupt-state write |
| icache_flush | output | 1 | Instruction-cache control pulse |
| dcache_flush | output | 1 | Data-cache control pulse |
| int_en | output | 3 | Interrupt enable and its two saved copies |
| int_mask | output | NUM_IRQ | Interrupt mask |
| int_pend | output | NUM_IRQ | Pending interrupts |
| exc_base | output | XLEN | Exception vector base |
| dbg_base | output | XLEN | Debug exception vector base |
| dbg_ctrl | output | XLEN | Debug control word |
| bp_addr | output | 4*XLEN | Breakpoint values, slot n at [XLEN*n +: XLEN] |
| wp_addr | output | 4*XLEN | Watchpoint values, slot n at [XLEN*n +: XLEN] |

## Verification
Every response is due exactly one clock edge after its access: read data, the three flags and the flush pulses. State written by an access shows on the output ports after that same edge. The driver stamps each expected item with the bench's edge count plus one. The monitor compares only items whose stamp matches the current count, at the falling edge, while the outputs are stable. Counter reads expect the bench's own count of edges since reset. Pending values are predicted from when the irq lines were driven relative to the edge.

// File: rtl/csr_bank.sv
module csr_bank #(
  parameter int XLEN = 32,
  parameter int NUM_IRQ = 16,
  parameter int NUM_BP = 2,
  parameter int NUM_WP = 3,
  parameter logic [XLEN-1:0] CFG_VALUE = 'h0012_0A37
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [4:0]          idx,
  input  logic [XLEN-1:0]     wr_data,
  input  logic [NUM_IRQ-1:0]  irq_lines,
  output logic [XLEN-1:0]     rd_data,
  output logic                acc_err,
  output logic                ill_insn,
  output logic                upd_req,
  output logic                icache_flush,
  output logic                dcache_flush,
  output logic [2:0]          int_en,
  output logic [NUM_IRQ-1:0]  int_mask,
  output logic [NUM_IRQ-1:0]  int_pend,
  output logic [XLEN-1:0]     exc_base,
  output logic [XLEN-1:0]     dbg_base,
  output logic [XLEN-1:0]     dbg_ctrl,
  output logic [4*XLEN-1:0]   bp_addr,
  output logic [4*XLEN-1:0]   wp_addr
);
  localparam int SLOTS = 4;
  localparam logic [4:0] IX_INTEN  = 5'd0;
  localparam logic [4:0] IX_INTMSK = 5'd1;
  localparam logic [4:0] IX_INTPND = 5'd2;
  localparam logic [4:0] IX_ICTL   = 5'd3;
  localparam logic [4:0] IX_DCTL   = 5'd4;
  localparam logic [4:0] IX_CYCLES = 5'd5;
  localparam logic [4:0] IX_CONFIG = 5'd6;
  localparam logic [4:0] IX_EXCB   = 5'd7;
  localparam logic [4:0] IX_DBGC   = 5'd8;
  localparam logic [4:0] IX_DBGB   = 5'd9;

  logic [XLEN-1:0] cyc_q;
  logic [XLEN-1:0] rd_mux;

  logic hit_en, hit_msk, hit_pnd, hit_ic, hit_dc, hit_cyc, hit_cfg;
  logic hit_exb, hit_dbc, hit_dbb, hit_bp, hit_wp, bp_ok, wp_ok, known;
  logic [1:0] slot;

  assign hit_en  = idx == IX_INTEN;
  assign hit_msk = idx == IX_INTMSK;
  assign hit_pnd = idx == IX_INTPND;
  assign hit_ic  = idx == IX_ICTL;
  assign hit_dc  = idx == IX_DCTL;
  assign hit_cyc = idx == IX_CYCLES;
  assign hit_cfg = idx == IX_CONFIG;
  assign hit_exb = idx == IX_EXCB;
  assign hit_dbc = idx == IX_DBGC;
  assign hit_dbb = idx == IX_DBGB;
  assign hit_bp  = idx[4:2] == 3'b100;
  assign hit_wp  = idx[4:2] == 3'b101;
  assign slot    = idx[1:0];
  assign bp_ok   = hit_bp && (int'(slot) < NUM_BP);
  assign wp_ok   = hit_wp && (int'(slot) < NUM_WP);
  assign known   = hit_en | hit_msk | hit_pnd | hit_ic | hit_dc | hit_cyc | hit_cfg |
                   hit_exb | hit_dbc | hit_dbb | hit_bp | hit_wp;

  logic wr_bad, rd_bad, wr_ill, wr_go, rd_go;
  assign wr_bad = wr_en && (hit_cyc || hit_cfg || !known);
  assign rd_bad = rd_en && (hit_ic || hit_dc || hit_bp || hit_wp || !known);
  assign wr_ill = wr_en && ((hit_bp && !bp_ok) || (hit_wp && !wp_ok));
  assign wr_go  = wr_en && known && !hit_cyc && !hit_cfg;
  assign rd_go  = rd_en && !rd_bad;

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit_en:  rd_mux = XLEN'(int_en);
      hit_msk: rd_mux = XLEN'(int_mask);
      hit_pnd: rd_mux = XLEN'(int_pend);
      hit_cyc: rd_mux = cyc_q;
      hit_cfg: rd_mux = CFG_VALUE;
      hit_exb: rd_mux = exc_base;
      hit_dbc: rd_mux = dbg_ctrl;
      hit_dbb: rd_mux = dbg_base;
      default: rd_mux = '0;
    endcase
  end

  logic [NUM_IRQ-1:0] pnd_clr;
  assign pnd_clr = (wr_go && hit_pnd) ? wr_data[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q        <= '0;
      rd_data      <= '0;
      acc_err      <= 1'b0;
      ill_insn     <= 1'b0;
      upd_req      <= 1'b0;
      icache_flush <= 1'b0;
      dcache_flush <= 1'b0;
      int_en       <= '0;
      int_mask     <= '0;
      int_pend     <= '0;
      exc_base     <= '0;
      dbg_base     <= '0;
      dbg_ctrl     <= '0;
    end else begin
      cyc_q        <= cyc_q + 1'b1;
      rd_data      <= rd_go ? rd_mux : '0;
      acc_err      <= wr_bad || rd_bad;
      ill_insn     <= wr_ill;
      upd_req      <= wr_go && (hit_en || hit_msk || hit_pnd);
      icache_flush <= wr_go && hit_ic;
      dcache_flush <= wr_go && hit_dc;
      int_pend     <= (int_pend & ~pnd_clr) | irq_lines;
      if (wr_go && hit_en)  int_en   <= wr_data[2:0];
      if (wr_go && hit_msk) int_mask <= wr_data[NUM_IRQ-1:0];
      if (wr_go && hit_exb) exc_base <= wr_data;
      if (wr_go && hit_dbc) dbg_ctrl <= wr_data;
      if (wr_go && hit_dbb) dbg_base <= wr_data;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_dbg
    if (g < NUM_BP) begin : g_bp
      logic [XLEN-1:0] bp_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bp_q <= '0;
        else if (wr_go && bp_ok && int'(slot) == g) bp_q <= wr_data;
      end
      assign bp_addr[g*XLEN +: XLEN] = bp_q;
    end else begin : g_bp_none
      assign bp_addr[g*XLEN +: XLEN] = '0;
    end
    if (g < NUM_WP) begin : g_wp
      logic [XLEN-1:0] wp_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wp_q <= '0;
        else if (wr_go && wp_ok && int'(slot) == g) wp_q <= wr_data;
      end
      assign wp_addr[g*XLEN +: XLEN] = wp_q;
    end else begin : g_wp_none
      assign wp_addr[g*XLEN +: XLEN] = '0;
    end
  end
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
  parameter int XLEN = 32,
  parameter int NUM_BP = 2,
  parameter int NUM_WP = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic            wr_en,
  input logic [4:0]      idx,
  input logic [XLEN-1:0] rd_data,
  input logic            acc_err,
  input logic            ill_insn,
  input logic            upd_req,
  input logic            icache_flush,
  input logic            dcache_flush,
  input logic [XLEN-1:0] cyc_q
);
  logic intwr, wo_rd, dbg_bad, unk;
  assign intwr   = wr_en && (idx <= 5'd2);
  assign wo_rd   = rd_en && !wr_en && (idx == 5'd3 || idx == 5'd4 || idx[4:3] == 2'b10);
  assign dbg_bad = wr_en && ((idx[4:2] == 3'b100 && int'(idx[1:0]) >= NUM_BP) ||
                             (idx[4:2] == 3'b101 && int'(idx[1:0]) >= NUM_WP));
  assign unk     = (idx >= 5'd10 && idx <= 5'd15) || idx >= 5'd24;

  AST_INTWR_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    intwr |=> upd_req); // R3
  AST_NO_STRAY_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !intwr |=> !upd_req); // R3
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cyc_q == $past(cyc_q) + 1'b1); // R5
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wo_rd |=> acc_err && rd_data == '0); // R7
  AST_DBG_SLOT_ILL: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_bad |=> ill_insn); // R8
  AST_ILL_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ill_insn |-> $past(wr_en)); // R8
  AST_UNKNOWN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && unk |=> acc_err && !ill_insn && !upd_req); // R9
  AST_IFLUSH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    icache_flush |-> $past(wr_en && idx == 5'd3)); // R10
  AST_DFLUSH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    dcache_flush |-> $past(wr_en && idx == 5'd4)); // R10
endmodule

bind csr_bank csr_bank_chk #(.XLEN(XLEN), .NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .idx(idx),
  .rd_data(rd_data), .acc_err(acc_err), .ill_insn(ill_insn), .upd_req(upd_req),
  .icache_flush(icache_flush), .dcache_flush(dcache_flush), .cyc_q(cyc_q)
);

// File: tb/csr_bank_tb_top.sv
module csr_bank_tb_top;
  localparam logic [31:0] CFGV = 32'h0012_0A37;

  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0] idx = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] irq_lines = '0;
  logic [31:0] rd_data;
  logic acc_err, ill_insn, upd_req, icache_flush, dcache_flush;
  logic [2:0] int_en;
  logic [15:0] int_mask, int_pend;
  logic [31:0] exc_base, dbg_base, dbg_ctrl;
  logic [127:0] bp_addr, wp_addr;

  csr_bank #(.XLEN(32), .NUM_IRQ(16), .NUM_BP(2), .NUM_WP(3), .CFG_VALUE(CFGV)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .idx(idx), .wr_data(wr_data),
    .irq_lines(irq_lines), .rd_data(rd_data), .acc_err(acc_err), .ill_insn(ill_insn),
    .upd_req(upd_req), .icache_flush(icache_flush), .dcache_flush(dcache_flush),
    .int_en(int_en), .int_mask(int_mask), .int_pend(int_pend), .exc_base(exc_base),
    .dbg_base(dbg_base), .dbg_ctrl(dbg_ctrl), .bp_addr(bp_addr), .wp_addr(wp_addr));

  always #5 clk = ~clk;

  typedef struct {
    int unsigned due;
    logic [31:0] rd;
    logic acc, ill, upd, icf, dcf;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int unsigned tick = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rst_n) tick <= tick + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == tick) begin
      e = q.pop_front();
      n_chk++;
      if (rd_data !== e.rd || acc_err !== e.acc || ill_insn !== e.ill || upd_req !== e.upd ||
          icache_flush !== e.icf || dcache_flush !== e.dcf) begin
        n_fail++;
        $display("FAIL %s: actual rd=%h acc=%b ill=%b upd=%b icf=%b dcf=%b expected rd=%h acc=%b ill=%b upd=%b icf=%b dcf=%b",
                 e.tag, rd_data, acc_err, ill_insn, upd_req, icache_flush, dcache_flush,
                 e.rd, e.acc, e.ill, e.upd, e.icf, e.dcf);
      end
    end
  end

  task automatic op(input logic r, input logic w, input logic [4:0] i, input logic [31:0] d,
                    input logic [31:0] erd, input logic eacc, input logic eill, input logic eupd,
                    input logic eicf, input logic edcf, input bit cyc_rd, input string tag);
    exp_t x;
    rd_en = r; wr_en = w; idx = i; wr_data = d;
    x.due = tick + 1; x.rd = cyc_rd ? tick : erd;
    x.acc = eacc; x.ill = eill; x.upd = eupd; x.icf = eicf; x.dcf = edcf; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d, input logic eacc,
                    input logic eill, input logic eupd, input string tag);
    op(1'b0, 1'b1, i, d, 32'h0, eacc, eill, eupd, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [4:0] i, input logic [31:0] erd, input logic eacc, input string tag);
    op(1'b1, 1'b0, i, 32'h0, erd, eacc, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    op(1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic chk(input logic [127:0] act, input logic [127:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({rd_data, acc_err, ill_insn, upd_req, icache_flush, dcache_flush}, '0, "R1 flags");
    chk({int_en, int_mask, int_pend, exc_base, dbg_base, dbg_ctrl}, '0, "R1 state");
    chk(bp_addr | wp_addr, '0, "R1 debug regs");
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R3 readable registers
    wr(5'd0, 32'hFFFF_FFFD, 1'b0, 1'b0, 1'b1, "R3 enable write");
    rd(5'd0, 32'h0000_0005, 1'b0, "R2 enable readback");
    wr(5'd1, 32'h1234_ABCD, 1'b0, 1'b0, 1'b1, "R3 mask write");
    rd(5'd1, 32'h0000_ABCD, 1'b0, "R2 mask readback");
    chk(int_mask, 128'hABCD, "R2 mask port");
    wr(5'd7, 32'h8000_0100, 1'b0, 1'b0, 1'b0, "R3 base write no update");
    rd(5'd7, 32'h8000_0100, 1'b0, "R2 exception base");
    wr(5'd9, 32'h9000_0200, 1'b0, 1'b0, 1'b0, "R3 debug base write");
    rd(5'd9, 32'h9000_0200, 1'b0, "R2 debug base");
    wr(5'd8, 32'h0000_00F3, 1'b0, 1'b0, 1'b0, "R3 debug ctrl write");
    rd(5'd8, 32'h0000_00F3, 1'b0, "R2 debug ctrl");

    // R6 read-only registers
    rd(5'd6, CFGV, 1'b0, "R6 config read");
    wr(5'd6, 32'h0, 1'b1, 1'b0, 1'b0, "R6 config write rejected");
    rd(5'd6, CFGV, 1'b0, "R6 config unchanged");
    wr(5'd5, 32'h0, 1'b1, 1'b0, 1'b0, "R6 counter write rejected");

    // R5 cycle counter
    op(1'b1, 1'b0, 5'd5, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 counter read a");
    idle("R5 gap");
    idle("R5 gap");
    op(1'b1, 1'b0, 5'd5, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 counter read b");

    // R4 pending
    irq_lines = 16'h0005;
    idle("R4 set lines");
    irq_lines = 16'h0000;
    rd(5'd2, 32'h0000_0005, 1'b0, "R4 pending captured");
    chk(int_pend, 128'h5, "R4 pending port");
    wr(5'd2, 32'h0000_0001, 1'b0, 1'b0, 1'b1, "R4 clear bit0");
    rd(5'd2, 32'h0000_0004, 1'b0, "R4 after clear");
    irq_lines = 16'h0002;
    wr(5'd2, 32'h0000_0006, 1'b0, 1'b0, 1'b1, "R4 set wins over clear");
    irq_lines = 16'h0000;
    rd(5'd2, 32'h0000_0002, 1'b0, "R4 set wins result");

    // R7 write-only reads
    rd(5'd3, 32'h0, 1'b1, "R7 icache read");
    rd(5'd4, 32'h0, 1'b1, "R7 dcache read");
    rd(5'd16, 32'h0, 1'b1, "R7 breakpoint read");
    rd(5'd22, 32'h0, 1'b1, "R7 watchpoint read");

    // R8 breakpoints and watchpoints
    wr(5'd16, 32'hAAAA_0000, 1'b0, 1'b0, 1'b0, "R8 bp0");
    wr(5'd17, 32'hBBBB_0004, 1'b0, 1'b0, 1'b0, "R8 bp1");
    wr(5'd18, 32'hCCCC_0008, 1'b0, 1'b1, 1'b0, "R8 bp2 absent");
    wr(5'd19, 32'hDDDD_000C, 1'b0, 1'b1, 1'b0, "R8 bp3 absent");
    chk(bp_addr, {64'h0, 32'hBBBB_0004, 32'hAAAA_0000}, "R8 bp values");
    wr(5'd20, 32'h1111_0010, 1'b0, 1'b0, 1'b0, "R8 wp0");
    wr(5'd21, 32'h2222_0020, 1'b0, 1'b0, 1'b0, "R8 wp1");
    wr(5'd22, 32'h3333_0030, 1'b0, 1'b0, 1'b0, "R8 wp2");
    wr(5'd23, 32'h4444_0040, 1'b0, 1'b1, 1'b0, "R8 wp3 absent");
    chk(wp_addr, {32'h0, 32'h3333_0030, 32'h2222_0020, 32'h1111_0010}, "R8 wp values");

    // R10 flush pulses
    op(1'b0, 1'b1, 5'd3, 32'h1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 icache pulse");
    op(1'b0, 1'b1, 5'd4, 32'h1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10 dcache pulse");
    idle("R10 pulse ends");

    // R9 unknown indexes
    wr(5'd10, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R9 write idx10");
    wr(5'd24, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R9 write idx24");
    rd(5'd31, 32'h0, 1'b1, "R9 read idx31");
    rd(5'd15, 32'h0, 1'b1, "R9 read idx15");
    rd(5'd7, 32'h8000_0100, 1'b0, "R9 base untouched");
    rd(5'd0, 32'h0000_0005, 1'b0, "R9 enable untouched");
    chk({int_mask, dbg_base, dbg_ctrl}, {16'hABCD, 32'h9000_0200, 32'h0000_00F3}, "R9 state untouched");
    chk(bp_addr | wp_addr, {32'h0, 32'h3333_0030, 32'hBBBB_0004 | 32'h2222_0020, 32'hAAAA_0000 | 32'h1111_0010}, "R9 debug untouched");
    idle("drain");
    idle("drain");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule